// File: doc/BRIEF.md
# Wrapping Burst Read Bus Sequencer

This block is a read-only bus master. It fills either one 32-bit word or a whole 128-bit line (four words) through a 16-bit external data bus. A request carries a start word address, a size flag and a mode flag. When the request is accepted, the block runs a series of halfword read beats. On every beat it drives the halfword address for that beat. It holds an active-low burst strobe over the burst and lets the memory stretch any beat with a wait input.

The two halves of each word arrive on consecutive beats, the high half first. They are joined into a 32-bit word, which is presented with a one-cycle valid pulse and its word index inside the line. A one-cycle done pulse follows the final word, and then the block returns to idle.

There are two modes. In cache-fill mode a line request always takes eight beats, and the address wraps around inside the line from any start word. In plain mode a line request runs from the start word up to the last halfword of the line, with no wrap. A single-word request takes two beats in both modes.

Top module: `burst_rd_seq`

## Requirements
- R1: After a synchronous active-low reset, `bus_act`, `word_valid`, `done` and `busy` are low and `bus_strobe_n` is high.
- R2: The number of completed beats is 2 for a single-word request (`req_line`=0). It is 8 for a line request in cache-fill mode (`req_icache`=1). It is 8 − 2·s for a line request in plain mode, where s is the start word `req_word_addr[1:0]`.
- R3: Beat k drives `bus_addr` = {`req_word_addr[WA-1:2]`, p}. Here p = (2·s + k) mod 8, a 3-bit halfword index whose bits [2:1] are the word and whose bit 0 is the half (0 = high half). The upper bits stay constant through the burst.
- R4: Each word is returned as `word_data` = {data of the half-0 beat, data of the half-1 beat}. `word_idx` equals bits [2:1] of that word's halfword index.
- R5: `bus_strobe_n` is low during every beat except the last beat of the burst, is high during the last beat, and is high whenever no beat is in progress.
- R6: A beat completes only at a rising clock edge where `bus_wait` is low. While `bus_wait` is high, the beat is extended and `bus_addr` holds its value.
- R7: `word_valid` is a one-cycle pulse, issued once per word, so a burst returns (beats / 2) words.
- R8: `done` is a single one-cycle pulse in the cycle right after the final `word_valid` of a burst. `busy` is high from the cycle after acceptance until `done` has been shown.
- R9: `req_valid` is accepted only when `busy` is low. A request raised while `busy` is high is ignored and does not change the running burst.
- R10: `bus_act` is high exactly while a beat is in progress. With `bus_wait` held low, it is high for exactly as many cycles as there are beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_word_addr | input | WA | Start word address (bits [1:0] give the word inside the line) |
| req_line | input | 1 | 1 = line fill, 0 = single word |
| req_icache | input | 1 | 1 = cache-fill mode with wrap, 0 = plain sequential mode |
| bus_addr | output | WA+1 | Halfword address of the current beat (zero when idle) |
| bus_act | output | 1 | High while a beat is in progress |
| bus_strobe_n | output | 1 | Active-low burst strobe |
| bus_wait | input | 1 | High stretches the current beat |
| bus_rdata | input | 16 | Halfword read data, sampled when the beat completes |
| word_valid | output | 1 | One-cycle pulse marking a returned word |
| word_data | output | 32 | Assembled word, high half first |
| word_idx | output | 2 | Word index of the returned word inside the line |
| done | output | 1 | One-cycle pulse after the final word |
| busy | output | 1 | High while a burst is under way |

## Verification
Each of the four start words is driven in cache-fill line mode, in plain line mode and as a single-word request. Comparing the two line modes shows wrap apart from truncation. The single-word runs show that size overrides mode.

Runs with waits held low measure the bare beat count and the strobe placement. Runs with dense random waits show that a stretched beat keeps its address and is counted once. A request raised in the middle of a burst shows that the block ignores requests while busy.

// File: rtl/burst_seq_pkg.sv
// Package: shared state encoding and beat-count rule for the burst sequencer.
// Assumes: a line holds four 32-bit words, that is eight 16-bit beats.
package burst_seq_pkg;

    localparam int BEATS_PER_LINE = 8;
    localparam int BEAT_CNT_W     = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FLUSH = 2'd2,
        ST_FIN   = 2'd3
    } seq_state_t;

    // Number of halfword beats for a request.
    function automatic logic [BEAT_CNT_W-1:0] beat_total(
        input logic       line,
        input logic       icache,
        input logic [1:0] start_word
    );
        if (!line)
            return BEAT_CNT_W'(2);
        else if (icache)
            return BEAT_CNT_W'(BEATS_PER_LINE);
        else
            return BEAT_CNT_W'(BEATS_PER_LINE) - {1'b0, start_word, 1'b0};
    endfunction

endpackage

// File: rtl/burst_ctrl.sv
// Module: burst_ctrl
// Sequence controller. It accepts a request only in idle, runs beats until the
// last one completes without wait, then spends one cycle on the final word
// pulse and one cycle on the done pulse before it returns to idle.
// Assumes: last_beat comes from registered beat state.
module burst_ctrl
    import burst_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       bus_wait,
    input  logic       last_beat,
    output logic       load,
    output logic       beat_adv,
    output seq_state_t state
);

    // Acceptance only when idle; a beat advances when running without wait.
    always_comb begin
        load     = (state == ST_IDLE) && req_valid;
        beat_adv = (state == ST_RUN) && !bus_wait;
    end

    // State register and transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:  if (req_valid) state <= ST_RUN;
                ST_RUN:   if (beat_adv && last_beat) state <= ST_FLUSH;
                ST_FLUSH: state <= ST_FIN;
                ST_FIN:   state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/burst_addr_gen.sv
// Module: burst_addr_gen
// Holds the line address and a 3-bit halfword pointer that steps modulo 8,
// so the pointer wraps inside the line. It also counts completed beats
// against the total for the request.
// Assumes: load and beat_adv are never high together.
module burst_addr_gen
    import burst_seq_pkg::*;
#(
    parameter int WA = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [WA-1:0] req_word_addr,
    input  logic          req_line,
    input  logic          req_icache,
    input  logic          beat_adv,
    output logic [WA:0]   hw_addr,
    output logic [2:0]    half_ptr,
    output logic          last_beat
);

    localparam int LINE_W = WA - 2;

    logic [LINE_W-1:0]     line_q;
    logic [2:0]            ptr_q;
    logic [BEAT_CNT_W-1:0] cnt_q;
    logic [BEAT_CNT_W-1:0] total_q;

    // Latch the request; step the pointer and the beat count per beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q  <= '0;
            ptr_q   <= '0;
            cnt_q   <= '0;
            total_q <= '0;
        end else if (load) begin
            line_q  <= req_word_addr[WA-1:2];
            ptr_q   <= {req_word_addr[1:0], 1'b0};
            cnt_q   <= '0;
            total_q <= beat_total(req_line, req_icache, req_word_addr[1:0]);
        end else if (beat_adv) begin
            ptr_q <= ptr_q + 3'd1;
            cnt_q <= cnt_q + BEAT_CNT_W'(1);
        end
    end

    // Present the address and flag the final beat.
    always_comb begin
        hw_addr   = {line_q, ptr_q};
        half_ptr  = ptr_q;
        last_beat = (cnt_q == total_q - BEAT_CNT_W'(1));
    end

endmodule

// File: rtl/burst_word_pack.sv
// Module: burst_word_pack
// Keeps the high half and, when the low half completes, issues the joined
// word with a one-cycle valid pulse and its word index.
// Assumes: each word takes two beats, high half (pointer bit 0 = 0) first.
module burst_word_pack (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        beat_adv,
    input  logic [2:0]  half_ptr,
    input  logic [15:0] rdata,
    output logic        word_valid,
    output logic [31:0] word_data,
    output logic [1:0]  word_idx
);

    logic [15:0] hi_q;

    // Capture halves and pulse the valid flag on the second half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q       <= '0;
            word_valid <= 1'b0;
            word_data  <= '0;
            word_idx   <= '0;
        end else begin
            word_valid <= 1'b0;
            if (beat_adv) begin
                if (!half_ptr[0]) begin
                    hi_q <= rdata;
                end else begin
                    word_valid <= 1'b1;
                    word_data  <= {hi_q, rdata};
                    word_idx   <= half_ptr[2:1];
                end
            end
        end
    end

endmodule

// File: rtl/burst_rd_seq.sv
// Module: burst_rd_seq (top)
// Wrapping burst read sequencer. It fetches one word or a 128-bit line over a
// 16-bit bus, high half first, with wait stretching and an active-low burst
// strobe. The strobe is released during the final beat.
// Assumes: memory data is valid whenever bus_wait is low during a beat.
module burst_rd_seq
    import burst_seq_pkg::*;
#(
    parameter int WA = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [WA-1:0] req_word_addr,
    input  logic          req_line,
    input  logic          req_icache,
    output logic [WA:0]   bus_addr,
    output logic          bus_act,
    output logic          bus_strobe_n,
    input  logic          bus_wait,
    input  logic [15:0]   bus_rdata,
    output logic          word_valid,
    output logic [31:0]   word_data,
    output logic [1:0]    word_idx,
    output logic          done,
    output logic          busy
);

    seq_state_t  state;
    logic        load;
    logic        beat_adv;
    logic        last_beat;
    logic [WA:0] hw_addr;
    logic [2:0]  half_ptr;

    burst_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .bus_wait  (bus_wait),
        .last_beat (last_beat),
        .load      (load),
        .beat_adv  (beat_adv),
        .state     (state)
    );

    burst_addr_gen #(.WA(WA)) u_addr (
        .clk           (clk),
        .rst_n         (rst_n),
        .load          (load),
        .req_word_addr (req_word_addr),
        .req_line      (req_line),
        .req_icache    (req_icache),
        .beat_adv      (beat_adv),
        .hw_addr       (hw_addr),
        .half_ptr      (half_ptr),
        .last_beat     (last_beat)
    );

    burst_word_pack u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_adv   (beat_adv),
        .half_ptr   (half_ptr),
        .rdata      (bus_rdata),
        .word_valid (word_valid),
        .word_data  (word_data),
        .word_idx   (word_idx)
    );

    // Bus-side outputs and status decoded from the controller state.
    always_comb begin
        bus_act      = (state == ST_RUN);
        bus_addr     = bus_act ? hw_addr : '0;
        bus_strobe_n = !(bus_act && !last_beat);
        done         = (state == ST_FIN);
        busy         = (state != ST_IDLE);
    end

endmodule

// File: rtl/burst_rd_seq_chk.sv
// Module: burst_rd_seq_chk
// Temporal checks on the sequencer ports, attached to every instance by bind.
module burst_rd_seq_chk #(
    parameter int WA = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic [WA:0] bus_addr,
    input logic        bus_act,
    input logic        bus_strobe_n,
    input logic        bus_wait,
    input logic        word_valid,
    input logic        done,
    input logic        busy
);

    AST_RESET_QUIET: assert property (@(posedge clk) $past(!rst_n) |-> (!bus_act && bus_strobe_n && !busy)); // R1
    AST_STEP_MOD8: assert property (@(posedge clk) disable iff (!rst_n) (bus_act && !bus_wait) |=> (!bus_act || bus_addr[2:0] == $past(bus_addr[2:0]) + 3'd1)); // R3
    AST_LINE_HELD: assert property (@(posedge clk) disable iff (!rst_n) (bus_act && $past(bus_act)) |-> bus_addr[WA:3] == $past(bus_addr[WA:3])); // R3
    AST_STRB_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !bus_act |-> bus_strobe_n); // R5
    AST_STRB_FIRST: assert property (@(posedge clk) disable iff (!rst_n) $rose(bus_act) |-> !bus_strobe_n); // R5
    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (bus_act && bus_wait) |=> (bus_act && $stable(bus_addr))); // R6
    AST_WV_PULSE: assert property (@(posedge clk) disable iff (!rst_n) word_valid |=> !word_valid); // R7
    AST_DONE_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(word_valid)); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> (!done && !busy)); // R8
    AST_ACT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) bus_act |-> busy); // R10

endmodule

bind burst_rd_seq burst_rd_seq_chk #(.WA(WA)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_act      (bus_act),
    .bus_strobe_n (bus_strobe_n),
    .bus_wait     (bus_wait),
    .word_valid   (word_valid),
    .done         (done),
    .busy         (busy)
);

// File: tb/tb_burst_rd_seq.sv
// Bench: a table of burst requests is walked by one loop, then directed tests
// cover reset, waits held low, dense waits and a request raised mid-burst.
module tb_burst_rd_seq;

    localparam int WA     = 16;
    localparam int LINE_W = WA - 2;

    typedef struct packed {
        logic       line;
        logic       icache;
        logic [1:0] start;
        logic [3:0] beats;
        logic [3:0] wthr;
    } vec_t;

    localparam vec_t VECS [0:11] = '{
        '{1'b1, 1'b1, 2'd0, 4'd8, 4'd4},
        '{1'b1, 1'b1, 2'd1, 4'd8, 4'd6},
        '{1'b1, 1'b1, 2'd2, 4'd8, 4'd2},
        '{1'b1, 1'b1, 2'd3, 4'd8, 4'd8},
        '{1'b1, 1'b0, 2'd0, 4'd8, 4'd5},
        '{1'b1, 1'b0, 2'd1, 4'd6, 4'd3},
        '{1'b1, 1'b0, 2'd2, 4'd4, 4'd7},
        '{1'b1, 1'b0, 2'd3, 4'd2, 4'd4},
        '{1'b0, 1'b0, 2'd1, 4'd2, 4'd6},
        '{1'b0, 1'b0, 2'd2, 4'd2, 4'd0},
        '{1'b0, 1'b1, 2'd3, 4'd2, 4'd9},
        '{1'b0, 1'b1, 2'd0, 4'd2, 4'd3}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic [WA-1:0] req_word_addr;
    logic          req_line;
    logic          req_icache;
    logic [WA:0]   bus_addr;
    logic          bus_act;
    logic          bus_strobe_n;
    logic          bus_wait;
    logic [15:0]   bus_rdata;
    logic          word_valid;
    logic [31:0]   word_data;
    logic [1:0]    word_idx;
    logic          done;
    logic          busy;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    // Memory model: data derived from the halfword address.
    function automatic logic [15:0] mem_hw(input logic [WA:0] a);
        logic [31:0] t;
        t = {15'd0, a} * 32'd40503;
        return t[18:3] ^ 16'h5A3C;
    endfunction

    assign bus_rdata = mem_hw(bus_addr);

    burst_rd_seq #(.WA(WA)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_word_addr (req_word_addr),
        .req_line      (req_line),
        .req_icache    (req_icache),
        .bus_addr      (bus_addr),
        .bus_act       (bus_act),
        .bus_strobe_n  (bus_strobe_n),
        .bus_wait      (bus_wait),
        .bus_rdata     (bus_rdata),
        .word_valid    (word_valid),
        .word_data     (word_data),
        .word_idx      (word_idx),
        .done          (done),
        .busy          (busy)
    );

    // Monitor logs
    logic [WA:0]  log_addr  [0:15];
    logic         log_strb  [0:15];
    logic [31:0]  log_wdata [0:7];
    logic [1:0]   log_widx  [0:7];
    int           nbeat, nword, ndone, nact, cyc, last_wv_cyc, done_cyc;
    logic [3:0]   wait_thr = 4'd0;
    logic [15:0]  lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        nbeat = 0; nword = 0; ndone = 0; nact = 0;
        last_wv_cyc = -10; done_cyc = -20;
    endtask

    // Drives the wait input at falling edges and logs outputs there.
    initial begin
        bus_wait = 1'b0;
        cyc = 0;
        clear_logs();
        forever begin
            logic w;
            @(negedge clk);
            cyc++;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            w = (lfsr[3:0] < wait_thr);
            bus_wait = w;
            if (bus_act) nact++;
            if (bus_act && !w && nbeat < 16) begin
                log_addr[nbeat] = bus_addr;
                log_strb[nbeat] = bus_strobe_n;
                nbeat++;
            end
            if (word_valid && nword < 8) begin
                log_wdata[nword] = word_data;
                log_widx[nword]  = word_idx;
                nword++;
                last_wv_cyc = cyc;
            end
            if (done) begin
                ndone++;
                done_cyc = cyc;
            end
        end
    end

    // Issue one request; optionally raise a second request mid-burst.
    task automatic run_burst(input logic line, input logic icache, input logic [WA-1:0] wa,
                             input bit intrude);
        clear_logs();
        @(negedge clk);
        req_word_addr = wa; req_line = line; req_icache = icache; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (intrude) begin
            repeat (2) @(negedge clk);
            req_word_addr = wa ^ {{(WA-2){1'b1}}, 2'b01};
            req_line = 1'b1; req_icache = ~icache; req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        for (int i = 0; i < 400 && ndone == 0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic check_burst(input logic [WA-1:0] wa, input int beats, input string tag);
        logic [2:0] p;
        logic [WA:0] ea;
        chk(nbeat == beats, {"R2 beat count ", tag}, 64'(nbeat), 64'(beats));
        for (int k = 0; k < beats && k < nbeat; k++) begin
            p  = 3'({wa[1:0], 1'b0} + k);
            ea = {wa[WA-1:2], p};
            chk(log_addr[k] == ea, {"R3 address ", tag}, 64'(log_addr[k]), 64'(ea));
            chk(log_strb[k] == (k == beats - 1), {"R5 strobe ", tag}, 64'(log_strb[k]), 64'(k == beats - 1));
        end
        chk(nword == beats / 2, {"R7 word count ", tag}, 64'(nword), 64'(beats / 2));
        for (int j = 0; j < beats / 2 && j < nword; j++) begin
            logic [WA:0] ah;
            logic [31:0] ed;
            p  = 3'({wa[1:0], 1'b0} + 2 * j);
            ah = {wa[WA-1:2], p};
            ed = {mem_hw(ah), mem_hw(ah + 1'b1)};
            chk(log_wdata[j] == ed, {"R4 word data ", tag}, 64'(log_wdata[j]), 64'(ed));
            chk(log_widx[j] == p[2:1], {"R4 word index ", tag}, 64'(log_widx[j]), 64'(p[2:1]));
        end
        chk(ndone == 1, {"R8 done count ", tag}, 64'(ndone), 64'd1);
        chk(done_cyc == last_wv_cyc + 1, {"R8 done timing ", tag}, 64'(done_cyc - last_wv_cyc), 64'd1);
        chk(!busy, {"R8 idle after done ", tag}, 64'(busy), 64'd0);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired act=hung exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_word_addr = '0; req_line = 1'b0; req_icache = 1'b0;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(!bus_act && bus_strobe_n && !word_valid && !done && !busy, "R1 reset outputs",
            {59'd0, bus_act, bus_strobe_n, word_valid, done, busy}, 64'h08);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!bus_act && bus_strobe_n && !busy, "R1 idle after reset",
            {61'd0, bus_act, bus_strobe_n, busy}, 64'h2);

        // Table walk
        for (int i = 0; i < 12; i++) begin
            logic [WA-1:0] wa;
            wa = {LINE_W'(1000 + i * 37), VECS[i].start};
            wait_thr = VECS[i].wthr;
            run_burst(VECS[i].line, VECS[i].icache, wa, 1'b0);
            check_burst(wa, int'(VECS[i].beats), $sformatf("vec%0d", i));
        end

        // R10 / R6: waits held low, beats equal active cycles
        wait_thr = 4'd0;
        run_burst(1'b1, 1'b1, {LINE_W'(77), 2'd2}, 1'b0);
        check_burst({LINE_W'(77), 2'd2}, 8, "nowait");
        chk(nact == 8, "R10 active cycles without wait", 64'(nact), 64'd8);

        // R6: dense waits, beats still counted once each
        wait_thr = 4'd13;
        run_burst(1'b1, 1'b0, {LINE_W'(5), 2'd1}, 1'b0);
        check_burst({LINE_W'(5), 2'd1}, 6, "densewait");
        chk(nact > 6, "R6 waits stretch beats", 64'(nact), 64'd7);

        // R9: request raised during a burst is ignored
        wait_thr = 4'd6;
        run_burst(1'b1, 1'b1, {LINE_W'(300), 2'd3}, 1'b1);
        check_burst({LINE_W'(300), 2'd3}, 8, "R9 intrude");
        repeat (20) @(negedge clk);
        chk(!busy && !bus_act, "R9 no second burst started", {62'd0, busy, bus_act}, 64'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule